// File: doc/BRIEF.md
# Single-Clock FIFO with Registered-Read Collision Bypass

This block is a first-in first-out buffer on one clock. Writes are accepted while space remains, and reads are accepted while data is present. The oldest stored word is always visible on the read data output whenever the buffer is not empty, so a consumer can sample the word and pulse the read enable to drop it. Full and empty flags come straight from an occupancy counter.

The storage array can be built in one of two ways, chosen by a parameter. With a combinational read, the array is indexed by the current read pointer. With a registered read, it behaves like on-chip block memory: the array is read on the clock edge at the address the read pointer is about to take. A registered read returns the old content when the array is written and read at the same address on the same edge. To cover that case, a bypass register keeps the last write data, and a registered select flag steers the output to it for one cycle. The two styles look the same at the ports.

A typical use is a rate-matching queue between two pipeline stages that share a clock. The registered style lets the array map onto block memory without changing what the consumer sees.

Top module: `sfifo_bypass`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were accepted. Whenever `empty` is 0, `rd_data` shows the oldest stored word. A read is accepted on a clock edge where `rd_en` is 1 and `empty` is 0.
- R3: A write while `full` is 1 and `rd_en` is 0 is ignored. The flag stays set and the stored words are unchanged.
- R4: A read request while `empty` is 1 is ignored, even if a write is accepted on the same edge. That written word becomes visible on `rd_data`, with `empty` at 0, in the cycle after that edge.
- R5: A word written on an edge where the write address equals the address the read pointer moves to (leaving empty, or a read and a write with one word stored) is shown on `rd_data` in the very next cycle, not stale array content.
- R6: A simultaneous read and write while `full` is 1 are both accepted. `full` stays 1, and the read drops the stored oldest word, not the incoming one.
- R7: `full` is 1 exactly when DEPTH words are held, and `empty` is 1 exactly when none are held. The two are never 1 together.
- R8: The combinational-read style and the registered-read style produce identical `rd_data`, `full` and `empty` for the same input sequence.
- R9: Both pointers wrap modulo DEPTH, so FIFO order holds across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request (drops the shown word) |
| rd_data | output | WIDTH | Oldest stored word, valid while empty is 0 |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No words held |

## Verification
The bench targets these corner cases:
- **Leaving empty while a read request is held.** A design that accepted that read would lose the word. One that lacked the bypass would show stale memory for a cycle.
- **A steady stream of one write and one read every cycle at occupancy one.** Every word here must take the bypass. A wrong select comparison shows the previous lap's data.
- **Writes into a full buffer, with and without a read on the same edge.** An overflow here corrupts the order, and a refused simultaneous write drops a word.
- **Equivalence of the two styles.** Both styles run in parallel under long pseudo-random traffic on a small depth, so the pointers wrap many times.

// File: rtl/sfifo_pkg.sv
// Shared definitions for the single-clock FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sfifo_pkg;

    // Storage read style selector.
    typedef enum logic {
        RD_COMB = 1'b0,   // array indexed combinationally by the read pointer
        RD_REG  = 1'b1    // array read on the clock edge, with collision bypass
    } rd_style_e;

endpackage

// File: rtl/sfifo_ctrl.sv
// Pointer and occupancy control for the FIFO.
// Decides which requests are accepted, keeps both pointers (wrapping modulo
// DEPTH) and the occupancy count, and provides the pointer value the read
// side will hold after the coming edge.
// Assumes DEPTH >= 2; synchronous active-low reset.
module sfifo_ctrl #(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] rd_ptr_nxt,
    output logic             full,
    output logic             empty
);

    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Accept requests and work out where the read pointer is heading.
    always_comb begin
        rd_fire    = rd_en && !empty;
        wr_fire    = wr_en && (!full || rd_fire);
        rd_ptr_nxt = rd_fire ? ptr_inc(rd_ptr) : rd_ptr;
    end

    // Advance pointers and occupancy on accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_fire) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            rd_ptr <= rd_ptr_nxt;
            case ({wr_fire, rd_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && wr_ptr == $past(wr_ptr)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> (rd_ptr == $past(rd_ptr)));

    assert_full_rw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> full);

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/sfifo_store_comb.sv
// Storage array with a combinational read at the current read pointer.
// Writes land on the rising edge at wr_ptr when wr_fire is set.
// Assumes the controller keeps pointers below DEPTH.
module sfifo_store_comb #(
    parameter  int WIDTH = 32,
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] rd_ptr_nxt,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store accepted write data.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Present the word at the head of the queue.
    assign rd_data = mem[rd_ptr];

    // The pointer used here must be the one announced on the previous cycle.
    assert_ptr_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_ptr == $past(rd_ptr_nxt)));

endmodule

// File: rtl/sfifo_store_reg.sv
// Storage array with a registered read, as block memory would provide.
// The array is read on the edge at the pointer the read side is moving to,
// so the registered word belongs to the read pointer in the following cycle.
// A same-edge write to that address is not seen by the array read; a bypass
// register and a select flag return the fresh word instead.
// Assumes the controller keeps pointers below DEPTH; synchronous active-low
// reset clears only the select flag.
module sfifo_store_reg #(
    parameter  int WIDTH = 32,
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] rd_ptr_nxt,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] mem_q;
    logic [WIDTH-1:0] byp_q;
    logic             use_byp;

    // Array write plus early registered read; bypass captures every edge.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= wr_data;
        end
        mem_q <= mem[rd_ptr_nxt];
        byp_q <= wr_data;
    end

    // Flag a write aimed at the address the read side will show next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_byp <= 1'b0;
        end else begin
            use_byp <= wr_fire && (wr_ptr == rd_ptr_nxt);
        end
    end

    // Output mux: fresh write data on a collision, array word otherwise.
    assign rd_data = use_byp ? byp_q : mem_q;

    assert_bypass_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_ptr == rd_ptr_nxt) |=> (rd_data == $past(wr_data)));

    assert_ptr_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_ptr == $past(rd_ptr_nxt)));

endmodule

// File: rtl/sfifo_bypass.sv
// Top of the single-clock FIFO. The oldest word is always shown on rd_data
// while empty is low; rd_en drops it. READ_STYLE picks combinational or
// registered array reads; both give the same port behaviour.
// Assumes DEPTH >= 2; synchronous active-low reset.
module sfifo_bypass
    import sfifo_pkg::*;
#(
    parameter  int        WIDTH      = 32,
    parameter  int        DEPTH      = 16,
    parameter  rd_style_e READ_STYLE = RD_REG,
    localparam int        PTR_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);

    logic             wr_fire;
    logic             rd_fire;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] rd_ptr_nxt;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .rd_ptr_nxt (rd_ptr_nxt),
        .full       (full),
        .empty      (empty)
    );

    generate
        if (READ_STYLE == RD_REG) begin : g_reg
            sfifo_store_reg #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_fire    (wr_fire),
                .wr_ptr     (wr_ptr),
                .wr_data    (wr_data),
                .rd_ptr     (rd_ptr),
                .rd_ptr_nxt (rd_ptr_nxt),
                .rd_data    (rd_data)
            );
        end else begin : g_comb
            sfifo_store_comb #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_fire    (wr_fire),
                .wr_ptr     (wr_ptr),
                .wr_data    (wr_data),
                .rd_ptr     (rd_ptr),
                .rd_ptr_nxt (rd_ptr_nxt),
                .rd_data    (rd_data)
            );
        end
    endgenerate

    assert_leave_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_en) |=> !empty);

    assert_read_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |-> !empty);

endmodule

// File: tb/sfifo_bypass_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task applies requests, the monitor keeps the
// expected queue and compares both read styles against it every cycle.
module sfifo_bypass_test;
    import sfifo_pkg::*;

    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data, c_rd_data;
    logic         full, empty, c_full, c_empty;

    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    string        tag = "R1";
    logic [W-1:0] exp_q [$];

    always #2 clk = ~clk;

    sfifo_bypass #(.WIDTH(W), .DEPTH(D), .READ_STYLE(RD_REG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty));

    sfifo_bypass #(.WIDTH(W), .DEPTH(D), .READ_STYLE(RD_COMB)) uut_comb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(c_rd_data), .full(c_full), .empty(c_empty));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
        end
    endtask

    // Driver: requests apply at the next rising edge.
    task automatic cyc(input bit we, input logic [W-1:0] d, input bit re);
        @(posedge clk);
        #1;
        wr_en   = we;
        wr_data = d;
        rd_en   = re;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare outputs, then update the expected queue for the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int  sz = exp_q.size();
            automatic bit  rd_ok;
            automatic bit  wr_ok;
            check(empty == (sz == 0), "R7", "empty", empty, sz == 0);
            check(full == (sz == D), "R7", "full", full, sz == D);
            if (sz > 0) begin
                check(rd_data == exp_q[0], "R2", "rd_data", rd_data, exp_q[0]);
                check(c_rd_data == rd_data, "R8", "comb rd_data", c_rd_data, rd_data);
            end
            check(c_empty == empty && c_full == full, "R8", "comb flags",
                  {c_full, c_empty}, {full, empty});
            rd_ok = rd_en && sz > 0;
            wr_ok = wr_en && (sz < D || rd_ok);
            if (rd_ok) void'(exp_q.pop_front());
            if (wr_ok) exp_q.push_back(wr_data);
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        check(empty == 1'b1 && full == 1'b0, "R1", "flags after reset",
              {full, empty}, 2'b01);

        // R4: read on empty ignored while a write lands; word shown next cycle.
        tag = "R4";
        cyc(1'b1, 8'hA1, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        settle();
        check(!empty && rd_data == 8'hA1, "R4", "word after leaving empty",
              rd_data, 8'hA1);
        cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);

        // R5: write and read every cycle at occupancy one.
        tag = "R5";
        for (int i = 0; i < 10; i++) cyc(1'b1, 8'h10 + 8'(i), 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        settle();
        check(rd_data == 8'h19, "R5", "last streamed word", rd_data, 8'h19);
        cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);

        // R3: fill, then writes while full are dropped.
        tag = "R3";
        for (int i = 0; i < D; i++) cyc(1'b1, 8'h20 + 8'(i), 1'b0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 8'hEE, 1'b0);
        cyc(1'b0, 8'h00, 1'b0);
        settle();
        check(full && rd_data == 8'h20, "R3", "head after overflow attempts",
              rd_data, 8'h20);

        // R6: simultaneous read and write while full.
        tag = "R6";
        cyc(1'b1, 8'h30, 1'b1);
        cyc(1'b1, 8'h31, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        settle();
        check(full && rd_data == 8'h22, "R6", "head after full read+write",
              rd_data, 8'h22);

        // Drain past empty; extra reads are ignored.
        tag = "R4";
        for (int i = 0; i < D + 2; i++) cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        settle();
        check(empty == 1'b1, "R4", "empty after drain", empty, 1);

        // R9: pseudo-random traffic wrapping the pointers many times.
        tag = "R9";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[2] | lfsr[9]);
        end
        cyc(1'b0, 8'h00, 1'b0);
        settle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule